// File: doc/BRIEF.md
# Multi-Rail Power Sequencing Controller

This block orders the switch-on and switch-off of three step-down supply channels. Each channel is placed in one of three ordering positions, and more than one channel may share a position. On power-up the positions are visited in ascending order. For each occupied position the block first waits a programmable delay. It then raises the enables of every channel in that position together, and it waits until all of those channels report that their output has reached its target. Only then does it move on to the next position. Power-down visits the positions in descending order, using the same delays, and it drops each position's enables in turn.

The global enable input starts and stops the sequence. Register-style per-channel on/off commands switch single rails while the block is idle or fully on. A fault request either cuts every rail at once or sequences all rails down, depending on a configuration bit. A power-up timeout marks the sequence as failed and shuts the rails down. All delays are counted in ticks of a prescaled timebase taken from the system clock. The configuration is supplied on plain register ports.

Top module: `pwrseq_ctrl`

## Requirements
- R1: Each channel c takes its position from cfg_slot[2c+1:2c]: code 0 is the first position, code 1 the second, and codes 2 and 3 both mean the third. Any number of channels may share a position.
- R2: On power-up the positions are handled in ascending order. An occupied position waits its delay code (cfg_dly[4p+3:4p] for position p) times PRESCALE clock cycles and then raises the enables of all its channels in the same cycle. While power-up runs, no enable falls.
- R3: The delay of the next position does not start until every channel of the current position has its pg input high.
- R4: Deasserting sys_en while the block is fully on powers the rails down in descending position order. Each occupied position waits its delay and then drops all its enables, and no enable rises during power-down. The block ends in the off state.
- R5: A position with no channel assigned is passed in a single cycle with no delay, both on power-up and on power-down.
- R6: If sys_en falls during power-up, power-down begins at the highest position whose enables are already raised. Positions that were never raised stay off.
- R7: If the current position's channels are not all good within cfg_timeout ticks of their enable, stat_fail is set and the rails are sequenced down. After that the block does not restart until sys_en has been low for at least one cycle in the off state, which also clears stat_fail.
- R8: A fault request with cfg_flt_seq = 0 drops every enable and returns the block to the off state at the next clock edge, and it sets stat_trip.
- R9: A fault request with cfg_flt_seq = 1 sets stat_trip and sequences the rails down in descending order, with the normal delays.
- R10: In the off and fully-on states, a cmd_on bit raises and a cmd_off bit drops the matching enable; cmd_off wins when both are set. The commands are ignored during power-up and power-down.
- R11: stat_state encodes 0 = off, 1 = power-up delay, 2 = power-up waiting for good, 3 = fully on, 4 = power-down. After reset, stat_state, ch_en, stat_fail and stat_trip are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_en | input | 1 | Global enable: high starts power-up, low starts power-down |
| cmd_on | input | 3 | Per-channel switch-on command |
| cmd_off | input | 3 | Per-channel switch-off command |
| fault_req | input | 1 | Qualified fault shutdown request |
| pg | input | 3 | Per-channel output-reached-target flags |
| cfg_slot | input | 6 | Position code per channel, 2 bits each |
| cfg_dly | input | 12 | Delay code per position, 4 bits each, in ticks |
| cfg_timeout | input | 8 | Power-up good timeout in ticks |
| cfg_flt_seq | input | 1 | Fault response: 1 = sequence down, 0 = cut at once |
| ch_en | output | 3 | Channel enable and soft-start requests |
| stat_state | output | 3 | Sequencer state code |
| stat_slot | output | 2 | Position currently being handled |
| stat_fail | output | 1 | Power-up timeout occurred |
| stat_trip | output | 1 | Fault shutdown occurred |

## Verification
The bench sweeps every assignment of channels to positions, including shared and empty positions and the alias code 3, with a different delay set for each assignment. It measures the cycle of every enable edge against totals computed from the delays. A design that waited on an empty position, applied the delay after enabling, or reversed the power-down order would show its enable edges shifted or reordered. Directed cases drop sys_en in the middle of power-up, where a design that restarted power-down from the top position would waste delays or raise a rail that was never on. The directed cases also withhold one good flag to trigger the timeout, where a wrong window length or an automatic restart shows up. Further cases cover both fault responses and commands issued during sequencing, where a design that let the command through would flip an enable.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;
  localparam int NCH    = 3;
  localparam int NSLOT  = 3;
  localparam int SLOT_W = 2;

  typedef enum logic [2:0] {
    ST_OFF    = 3'd0,
    ST_UPDLY  = 3'd1,
    ST_UPWAIT = 3'd2,
    ST_ON     = 3'd3,
    ST_DN     = 3'd4
  } seq_st_e;
endpackage

// File: rtl/pwrseq_rst_sync.sv
module pwrseq_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/pwrseq_slotmap.sv
module pwrseq_slotmap
  import pwrseq_pkg::*;
(
  input  logic [SLOT_W*NCH-1:0]  cfg_slot,
  output logic [NSLOT*NCH-1:0]   slot_mask,
  output logic [NSLOT-1:0]       slot_empty
);
  logic [SLOT_W-1:0] pos_cl [NCH];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    // codes above the last position alias onto it
    assign pos_cl[c] = (cfg_slot[c*SLOT_W +: SLOT_W] > SLOT_W'(NSLOT-1)) ?
                       SLOT_W'(NSLOT-1) : cfg_slot[c*SLOT_W +: SLOT_W];
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    for (genvar c = 0; c < NCH; c++) begin : g_bit
      assign slot_mask[s*NCH + c] = (pos_cl[c] == SLOT_W'(s));
    end
    assign slot_empty[s] = ~|slot_mask[s*NCH +: NCH];
  end
endmodule

// File: rtl/pwrseq_tick.sv
module pwrseq_tick #(
  parameter int PRESCALE = 8,
  parameter int CNT_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  logic [PW-1:0]    pcnt_q, pcnt_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    pcnt_d = pcnt_q;
    cnt_d  = cnt_q;
    if (clr) begin
      pcnt_d = '0;
      cnt_d  = '0;
    end else if (pcnt_q == PW'(PRESCALE-1)) begin
      pcnt_d = '0;
      if (cnt_q != '1) cnt_d = cnt_q + CNT_W'(1);
    end else begin
      pcnt_d = pcnt_q + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q <= '0;
      cnt_q  <= '0;
    end else begin
      pcnt_q <= pcnt_d;
      cnt_q  <= cnt_d;
    end
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/pwrseq_ctrl.sv
module pwrseq_ctrl
  import pwrseq_pkg::*;
#(
  parameter int PRESCALE = 8,
  parameter int DLY_W    = 4,
  parameter int TO_W     = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sys_en,
  input  logic [NCH-1:0]          cmd_on,
  input  logic [NCH-1:0]          cmd_off,
  input  logic                    fault_req,
  input  logic [NCH-1:0]          pg,
  input  logic [SLOT_W*NCH-1:0]   cfg_slot,
  input  logic [DLY_W*NSLOT-1:0]  cfg_dly,
  input  logic [TO_W-1:0]         cfg_timeout,
  input  logic                    cfg_flt_seq,
  output logic [NCH-1:0]          ch_en,
  output logic [2:0]              stat_state,
  output logic [SLOT_W-1:0]       stat_slot,
  output logic                    stat_fail,
  output logic                    stat_trip
);
  localparam int CNT_W = (DLY_W > TO_W) ? DLY_W : TO_W;

  logic                  rst_n_s;
  logic [NSLOT*NCH-1:0]  slot_mask;
  logic [NSLOT-1:0]      slot_empty;
  logic [CNT_W-1:0]      tcnt;

  seq_st_e           st_q, st_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic [NCH-1:0]    en_q, en_d;
  logic              fail_q, fail_d, trip_q, trip_d;
  logic              adv;

  logic [NCH-1:0]    cur_mask;
  logic [DLY_W-1:0]  cur_dly;
  logic              cur_empty, dly_hit, to_hit, all_good, top, bot, abort, cut;
  logic [NCH-1:0]    cmd_next;

  pwrseq_rst_sync u_rst (.clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_n_s));

  pwrseq_slotmap u_map (.cfg_slot(cfg_slot), .slot_mask(slot_mask), .slot_empty(slot_empty));

  pwrseq_tick #(.PRESCALE(PRESCALE), .CNT_W(CNT_W)) u_tick (
    .clk(clk), .rst_n(rst_n_s),
    .clr(adv || st_q == ST_OFF || st_q == ST_ON),
    .cnt(tcnt)
  );

  assign cur_mask  = slot_mask[slot_q*NCH +: NCH];
  assign cur_empty = slot_empty[slot_q];
  assign cur_dly   = cfg_dly[slot_q*DLY_W +: DLY_W];
  assign dly_hit   = (tcnt == CNT_W'(cur_dly));
  assign to_hit    = (tcnt == CNT_W'(cfg_timeout));
  assign all_good  = ((pg & cur_mask) == cur_mask);
  assign top       = (slot_q == SLOT_W'(NSLOT-1));
  assign bot       = (slot_q == '0);
  assign abort     = fault_req || !sys_en;
  assign cut       = fault_req && !cfg_flt_seq;
  assign cmd_next  = (en_q | cmd_on) & ~cmd_off;

  always_comb begin
    st_d   = st_q;
    slot_d = slot_q;
    en_d   = en_q;
    fail_d = fail_q;
    trip_d = trip_q;
    adv    = 1'b0;
    unique case (st_q)
      ST_OFF: begin
        if (fault_req) begin
          en_d = '0;
        end else if (sys_en && !fail_q && !trip_q) begin
          st_d   = ST_UPDLY;
          slot_d = '0;
          adv    = 1'b1;
        end else begin
          if (!sys_en) begin
            fail_d = 1'b0;
            trip_d = 1'b0;
          end
          if (!fail_q && !trip_q) en_d = cmd_next;
        end
      end
      ST_UPDLY: begin
        if (abort) begin
          adv = 1'b1;
          if (fault_req) trip_d = 1'b1;
          if (cut || bot) begin
            en_d = '0;
            st_d = ST_OFF;
          end else begin
            st_d   = ST_DN;
            slot_d = slot_q - SLOT_W'(1);
          end
        end else if (cur_empty) begin
          adv = 1'b1;
          if (top) st_d = ST_ON;
          else     slot_d = slot_q + SLOT_W'(1);
        end else if (dly_hit) begin
          adv  = 1'b1;
          en_d = en_q | cur_mask;
          st_d = ST_UPWAIT;
        end
      end
      ST_UPWAIT: begin
        if (abort) begin
          adv = 1'b1;
          if (fault_req) trip_d = 1'b1;
          if (cut) begin
            en_d = '0;
            st_d = ST_OFF;
          end else begin
            st_d = ST_DN;
          end
        end else if (all_good) begin
          adv = 1'b1;
          if (top) begin
            st_d = ST_ON;
          end else begin
            st_d   = ST_UPDLY;
            slot_d = slot_q + SLOT_W'(1);
          end
        end else if (to_hit) begin
          adv    = 1'b1;
          fail_d = 1'b1;
          st_d   = ST_DN;
        end
      end
      ST_ON: begin
        if (abort) begin
          adv = 1'b1;
          if (fault_req) trip_d = 1'b1;
          if (cut) begin
            en_d = '0;
            st_d = ST_OFF;
          end else begin
            st_d   = ST_DN;
            slot_d = SLOT_W'(NSLOT-1);
          end
        end else begin
          en_d = cmd_next;
        end
      end
      ST_DN: begin
        if (fault_req) trip_d = 1'b1;
        if (cut) begin
          adv  = 1'b1;
          en_d = '0;
          st_d = ST_OFF;
        end else if (cur_empty || dly_hit) begin
          adv = 1'b1;
          if (!cur_empty) en_d = en_q & ~cur_mask;
          if (bot) st_d = ST_OFF;
          else     slot_d = slot_q - SLOT_W'(1);
        end
      end
      default: st_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      st_q   <= ST_OFF;
      slot_q <= '0;
      en_q   <= '0;
      fail_q <= 1'b0;
      trip_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      slot_q <= slot_d;
      en_q   <= en_d;
      fail_q <= fail_d;
      trip_q <= trip_d;
    end
  end

  assign ch_en      = en_q;
  assign stat_state = st_q;
  assign stat_slot  = slot_q;
  assign stat_fail  = fail_q;
  assign stat_trip  = trip_q;
endmodule

// File: rtl/pwrseq_ctrl_chk.sv
module pwrseq_ctrl_chk
  import pwrseq_pkg::*;
(
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] pg,
  input logic [NCH-1:0] ch_en,
  input logic           fault_req,
  input logic           cfg_flt_seq,
  input logic [2:0]     stat_state,
  input logic           stat_fail
);
  // R8: a cutting fault leaves nothing enabled one edge later
  assert_fault_cut_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_req && !cfg_flt_seq) |=> (ch_en == '0 && stat_state == 3'd0));

  // R2: during power-up an enable never falls
  assert_up_monotonic_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_state == 3'd1 || stat_state == 3'd2) &&
     ($past(stat_state) == 3'd1 || $past(stat_state) == 3'd2))
      |-> (($past(ch_en) & ~ch_en) == '0));

  // R4: during power-down an enable never rises
  assert_down_monotonic_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_state == 3'd4 && $past(stat_state) == 3'd4)
      |-> ((ch_en & ~$past(ch_en)) == '0));

  // R3: no advance while none of the enabled rails is good
  assert_wait_good_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_state == 3'd2 && (pg & ch_en) == '0)
      |=> (stat_state != 3'd1 && stat_state != 3'd3));

  // R7: the failure flag is only raised out of the good-wait phase
  assert_fail_origin_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_fail) |-> ($past(stat_state) == 3'd2 && stat_state == 3'd4));

  // R11: only the five defined state codes appear
  assert_state_legal_R11: assert property (@(posedge clk) disable iff (!rst_n)
    stat_state <= 3'd4);
endmodule

bind pwrseq_ctrl pwrseq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pg(pg), .ch_en(ch_en), .fault_req(fault_req),
  .cfg_flt_seq(cfg_flt_seq), .stat_state(stat_state), .stat_fail(stat_fail)
);

// File: tb/pwrseq_ctrl_tb.sv
module pwrseq_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int P = 2;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       sys_en, fault_req, cfg_flt_seq;
  logic [2:0] cmd_on, cmd_off, pg, pg_block, ch_en;
  logic [5:0] cfg_slot;
  logic [11:0] cfg_dly;
  logic [7:0] cfg_timeout;
  logic [2:0] stat_state;
  logic [1:0] stat_slot;
  logic       stat_fail, stat_trip;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  int d[3];
  int sl[3];
  int code[3];
  bit ne[3];
  int rise_at[3];
  int fall_at[3];
  bit ch2_seen;
  int start, at, x;

  pwrseq_ctrl #(.PRESCALE(P), .DLY_W(4), .TO_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .sys_en(sys_en), .cmd_on(cmd_on), .cmd_off(cmd_off),
    .fault_req(fault_req), .pg(pg), .cfg_slot(cfg_slot), .cfg_dly(cfg_dly),
    .cfg_timeout(cfg_timeout), .cfg_flt_seq(cfg_flt_seq), .ch_en(ch_en),
    .stat_state(stat_state), .stat_slot(stat_slot), .stat_fail(stat_fail),
    .stat_trip(stat_trip)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // rail model: good one cycle after enable, unless withheld
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) pg <= 3'b000;
    else        pg <= ch_en & ~pg_block;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic observe();
    @(negedge clk);
    for (int c = 0; c < 3; c++) begin
      if (ch_en[c] && rise_at[c] < 0) rise_at[c] = cyc;
      if (!ch_en[c] && fall_at[c] < 0) fall_at[c] = cyc;
    end
    if (ch_en[2]) ch2_seen = 1'b1;
  endtask

  task automatic clear_marks(input bit for_fall);
    for (int c = 0; c < 3; c++) begin
      rise_at[c] = for_fall ? 0 : -1;
      fall_at[c] = for_fall ? -1 : 0;
    end
    ch2_seen = 1'b0;
  endtask

  task automatic wait_state(input int tgt, output int when);
    when = -1;
    for (int i = 0; i < 3000; i++) begin
      observe();
      if (stat_state == 3'(tgt)) begin
        when = cyc;
        break;
      end
    end
  endtask

  task automatic wait_en(input logic [2:0] pat, output int when);
    when = -1;
    for (int i = 0; i < 3000; i++) begin
      observe();
      if (ch_en == pat) begin
        when = cyc;
        break;
      end
    end
  endtask

  function automatic int up_at(input int k);
    int t = 1;
    for (int j = 0; j < k; j++) t += ne[j] ? d[j]*P + 3 : 1;
    return t + d[k]*P + 1;
  endfunction

  function automatic int on_total();
    int t = 1;
    for (int j = 0; j < 3; j++) t += ne[j] ? d[j]*P + 3 : 1;
    return t;
  endfunction

  function automatic int dn_at(input int k);
    int t = 1;
    for (int j = 2; j > k; j--) t += ne[j] ? d[j]*P + 1 : 1;
    return t + d[k]*P + 1;
  endfunction

  function automatic int off_total();
    int t = 1;
    for (int j = 0; j < 3; j++) t += ne[j] ? d[j]*P + 1 : 1;
    return t;
  endfunction

  task automatic set_cfg();
    for (int c = 0; c < 3; c++) sl[c] = (code[c] > 2) ? 2 : code[c];
    for (int s = 0; s < 3; s++) ne[s] = 1'b0;
    for (int c = 0; c < 3; c++) ne[sl[c]] = 1'b1;
    cfg_slot = {2'(code[2]), 2'(code[1]), 2'(code[0])};
    cfg_dly  = {4'(d[2]), 4'(d[1]), 4'(d[0])};
  endtask

  task automatic power_up_full();
    sys_en = 1'b1;
    wait_state(3, at);
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sys_en = 1'b0; fault_req = 1'b0; cfg_flt_seq = 1'b0;
    cmd_on = '0; cmd_off = '0; pg_block = '0; cfg_timeout = 8'd20;
    cfg_slot = '0; cfg_dly = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11: reset state
    chk("R11", "reset state", int'(stat_state), 0);
    chk("R11", "reset enables", int'(ch_en), 0);
    chk("R11", "reset fail/trip", int'({stat_fail, stat_trip}), 0);

    // R1 R2 R4 R5: sweep of every position assignment
    for (int cfg = 0; cfg < 27; cfg++) begin
      code[0] = cfg % 3;
      code[1] = (cfg / 3) % 3;
      code[2] = cfg / 9;
      if (code[2] == 2 && (cfg % 2) == 1) code[2] = 3;
      for (int s = 0; s < 3; s++) d[s] = (cfg*(s+1) + s) % 6;
      set_cfg();
      clear_marks(1'b0);
      start = cyc;
      sys_en = 1'b1;
      wait_state(3, at);
      for (int c = 0; c < 3; c++)
        chk("R1,R2", $sformatf("cfg %0d ch%0d rise", cfg, c), rise_at[c] - start, up_at(sl[c]));
      chk("R5", $sformatf("cfg %0d on time", cfg), at - start, on_total());
      chk("R11", $sformatf("cfg %0d all on", cfg), int'(ch_en), 7);
      clear_marks(1'b1);
      start = cyc;
      sys_en = 1'b0;
      wait_state(0, at);
      for (int c = 0; c < 3; c++)
        chk("R4", $sformatf("cfg %0d ch%0d fall", cfg, c), fall_at[c] - start, dn_at(sl[c]));
      chk("R5", $sformatf("cfg %0d off time", cfg), at - start, off_total());
      @(negedge clk);
    end

    // fixed layout: ch0 first, ch1 second, ch2 third
    code[0] = 0; code[1] = 1; code[2] = 2;
    d[0] = 1; d[1] = 2; d[2] = 3;
    set_cfg();

    // R6: enable drops while position two waits for good
    clear_marks(1'b0);
    sys_en = 1'b1;
    wait_en(3'b011, x);
    clear_marks(1'b1);
    start = cyc;
    sys_en = 1'b0;
    wait_state(0, at);
    chk("R6", "ch1 fall", fall_at[1] - start, 2 + d[1]*P);
    chk("R6", "ch0 fall", fall_at[0] - start, 2 + d[1]*P + d[0]*P + 1);
    chk("R6", "ch2 never raised", int'(ch2_seen), 0);
    @(negedge clk);

    // R7: withheld good flag on ch1
    cfg_timeout = 8'd3;
    pg_block = 3'b010;
    clear_marks(1'b0);
    sys_en = 1'b1;
    wait_en(3'b011, x);
    at = -1;
    for (int i = 0; i < 200; i++) begin
      observe();
      if (stat_fail) begin at = cyc; break; end
    end
    chk("R7", "timeout window", at - x, 3*P + 1);
    wait_state(0, at);
    chk("R7", "ch2 never raised", int'(ch2_seen), 0);
    chk("R7", "rails off after fail", int'(ch_en), 0);
    repeat (5) @(negedge clk);
    chk("R7", "no restart while failed", int'(stat_state), 0);
    chk("R7", "fail held", int'(stat_fail), 1);
    sys_en = 1'b0;
    @(negedge clk);
    chk("R7", "fail cleared", int'(stat_fail), 0);
    pg_block = 3'b000;
    cfg_timeout = 8'd20;

    // R8: cutting fault from fully on
    power_up_full();
    cfg_flt_seq = 1'b0;
    fault_req = 1'b1;
    @(negedge clk);
    fault_req = 1'b0;
    chk("R8", "cut enables", int'(ch_en), 0);
    chk("R8", "cut state", int'(stat_state), 0);
    chk("R8", "trip set", int'(stat_trip), 1);
    repeat (3) @(negedge clk);
    chk("R8", "no restart while tripped", int'(stat_state), 0);
    sys_en = 1'b0;
    @(negedge clk);
    chk("R8", "trip cleared", int'(stat_trip), 0);

    // R9: sequenced fault response
    power_up_full();
    cfg_flt_seq = 1'b1;
    clear_marks(1'b1);
    start = cyc;
    fault_req = 1'b1;
    observe();
    fault_req = 1'b0;
    chk("R9", "enters power-down", int'(stat_state), 4);
    chk("R9", "rails still on", int'(ch_en), 7);
    chk("R9", "trip set", int'(stat_trip), 1);
    wait_state(0, at);
    chk("R9", "ch2 fall", fall_at[2] - start, dn_at(2));
    chk("R9", "ch0 fall", fall_at[0] - start, dn_at(0));
    sys_en = 1'b0;
    @(negedge clk);

    // R10: individual commands
    cmd_on = 3'b101;
    @(negedge clk);
    chk("R10", "cmd on in off", int'(ch_en), 5);
    cmd_on = 3'b010; cmd_off = 3'b010;
    @(negedge clk);
    chk("R10", "off wins", int'(ch_en), 5);
    cmd_on = 3'b000; cmd_off = 3'b001;
    @(negedge clk);
    chk("R10", "cmd off in off", int'(ch_en), 4);
    cmd_off = 3'b111;
    @(negedge clk);
    cmd_off = 3'b000;
    sys_en = 1'b1;
    @(negedge clk);
    cmd_on = 3'b100;
    @(negedge clk);
    cmd_on = 3'b000;
    chk("R10", "cmd ignored in power-up", int'(ch_en), 0);
    wait_state(3, at);
    cmd_off = 3'b001;
    @(negedge clk);
    cmd_off = 3'b000;
    chk("R10", "cmd off in on", int'(ch_en), 6);
    sys_en = 1'b0;
    wait_state(0, at);
    chk("R4", "final off", int'(ch_en), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule